// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial bus slave that gives a host controller byte-wide access to a bank of configuration registers. The host opens a transfer with a START condition. The first byte carries a 7-bit device address and a direction bit. In a write, the byte after the address loads an internal pointer. Each data byte after that goes to the register the pointer names, and the pointer then steps to the next address. A read returns register contents from the pointer onward, one register per byte. A single register can be reached by sending only one data byte.

Both bus lines pass through two-flop synchronizers into the system clock domain. A strap pin sets the low address bit and also chooses whether a pulse-rejection filter sits in front of the bus logic. SDA is never driven high: the block only produces an enable that pulls the line low.

Four registers form one 32-bit word for the core. That word is refreshed only when the last of the four bytes is written. Earlier bytes of the group wait in the register bank without disturbing the live value.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The slave answers only to the 7-bit address 110101S, where S is `addr_sel`. Byte bit 0 selects the direction: 1 is a read and 0 is a write. With `addr_sel` low the write byte is 0xD4 and the read byte is 0xD5. With `addr_sel` high they are 0xD6 and 0xD7. Any other address gets no acknowledge and changes no register.
- R2: In a write, the byte after the address loads the pointer and is acknowledged. Each later data byte is stored at the pointer, is acknowledged, and moves the pointer up by one. No register changes without a stored data byte.
- R3: A read returns register contents starting at the pointer and stepping upward. The pointer itself is never returned.
- R4: An active-low reset sets register i to (i XOR 0xA5) and releases SDA.
- R5: A pointer byte above the top address (default 0x3D) is not acknowledged, and the slave goes idle. The top address itself is accepted.
- R6: A write data byte whose pointer is above the top address is not stored and not acknowledged, and the slave goes idle.
- R7: A read that passes the top address keeps returning the top register until the host answers with a no-acknowledge.
- R8: `grp_word` holds registers 0x1C to 0x1F. Register 0x1C is bits 7:0 and register 0x1F is bits 31:24. The word changes only in the cycle after register 0x1F is written, and it then takes all four bytes.
- R9: A STOP in the middle of a byte sends the slave to idle and stores nothing. A START at any point begins a new transfer that expects an address byte.
- R10: With `addr_sel` low, pulses on SCL or SDA shorter than FILT_CYC clock cycles are ignored. With `addr_sel` high, the filter is bypassed.
- R11: SDA is only pulled low through `sda_oe`. The enable rises only while SCL is low and is clear after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when high |
| addr_sel | input | 1 | Strap: low address bit; low also enables the filter |
| cfg_regs | output | 8*(MAX_ADDR+1) | All registers, register i at bits 8*i+7:8*i |
| grp_word | output | 32 | Committed value of the four-byte group |

## Verification
The bench builds the block with its defaults: top address 0x3D, group base 0x1C and a 13-cycle filter, which is 52 ns at the bench clock. With a top address this low, both overrun cases and the rejected pointer byte can be reached in transfers of only a few bytes. The 13-cycle window lets a 5-cycle SCL glitch be injected between bits so the filter's effect shows in the stored value. Changing the strap during the run covers both slave addresses and the bypassed filter path.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
   typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} bus_st_t;
   typedef enum logic [1:0] {RX_ADDR, RX_SUB, RX_DATA} rx_kind_t;

   localparam logic [5:0] DEV_ADDR_HI = 6'b110101;
   localparam logic [7:0] RST_XOR     = 8'hA5;

   function automatic logic [7:0] reg_rst_val(input int idx);
      return 8'(idx) ^ RST_XOR;
   endfunction
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
   parameter int FILT_CYC = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic filt_en,
   output logic line_o
);
   localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);

   logic [1:0]    sync_q;
   logic          filt_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], line_i};
   end

   // a new level is accepted only after FILT_CYC cycles without a break
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q <= 1'b1;
         cnt_q  <= '0;
      end else if (sync_q[1] == filt_q) begin
         cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYC - 1)) begin
         filt_q <= sync_q[1];
         cnt_q  <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign line_o = filt_en ? filt_q : sync_q[1];
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
   import i2c_cfg_pkg::*;
#(
   parameter int MAX_ADDR = 61,
   parameter int GRP_BASE = 28
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [7:0]              wr_addr,
   input  logic [7:0]              wr_data,
   input  logic [7:0]              rd_addr,
   output logic [7:0]              rd_data,
   output logic [8*(MAX_ADDR+1)-1:0] regs_flat,
   output logic [31:0]             grp_word
);
   localparam int NREG = MAX_ADDR + 1;
   localparam int GRP_LAST = GRP_BASE + 3;

   logic [8*NREG-1:0] regs_q;
   logic [31:0]       grp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs_q[8*i +: 8] <= reg_rst_val(i);
      end else if (wr_en) begin
         for (int i = 0; i < NREG; i++)
            if (wr_addr == 8'(i)) regs_q[8*i +: 8] <= wr_data;
      end
   end

   // group word takes all four bytes when its highest byte lands
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         grp_q <= {reg_rst_val(GRP_BASE+3), reg_rst_val(GRP_BASE+2),
                   reg_rst_val(GRP_BASE+1), reg_rst_val(GRP_BASE)};
      else if (wr_en && wr_addr == 8'(GRP_LAST))
         grp_q <= {wr_data, regs_q[8*(GRP_BASE+2) +: 8],
                   regs_q[8*(GRP_BASE+1) +: 8], regs_q[8*GRP_BASE +: 8]};
   end

   // addresses past the top read back the top register
   always_comb begin
      rd_data = regs_q[8*MAX_ADDR +: 8];
      for (int i = 0; i < NREG; i++)
         if (rd_addr == 8'(i)) rd_data = regs_q[8*i +: 8];
   end

   assign regs_flat = regs_q;
   assign grp_word  = grp_q;
endmodule

// File: rtl/i2c_bus_fsm.sv
module i2c_bus_fsm
   import i2c_cfg_pkg::*;
#(
   parameter int MAX_ADDR = 61
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl,
   input  logic       sda,
   input  logic       strap,
   output logic       sda_oe,
   output logic       wr_en,
   output logic [7:0] wr_addr,
   output logic [7:0] wr_data,
   output logic [7:0] rd_addr,
   input  logic [7:0] rd_data
);
   localparam logic [7:0] TOP = 8'(MAX_ADDR);

   bus_st_t    st_q;
   rx_kind_t   kind_q;
   logic [3:0] cnt_q;
   logic [7:0] sh_q, ptr_q;
   logic       scl_q, sda_q, rw_q, oe_q, mack_q;

   logic scl_rise, scl_fall, start_c, stop_c;
   assign scl_rise = scl & ~scl_q;
   assign scl_fall = ~scl & scl_q;
   assign start_c  = scl & scl_q & sda_q & ~sda;
   assign stop_c   = scl & scl_q & ~sda_q & sda;

   logic [7:0] ptr_step;
   assign ptr_step = (ptr_q <= TOP) ? ptr_q + 8'd1 : ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         kind_q  <= RX_ADDR;
         cnt_q   <= '0;
         sh_q    <= '0;
         ptr_q   <= '0;
         rw_q    <= 1'b0;
         oe_q    <= 1'b0;
         mack_q  <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_c) begin
            st_q   <= ST_RX;
            kind_q <= RX_ADDR;
            cnt_q  <= '0;
            oe_q   <= 1'b0;
         end else if (stop_c) begin
            st_q <= ST_IDLE;
            oe_q <= 1'b0;
         end else begin
            unique case (st_q)
               ST_IDLE: ;
               ST_RX: begin
                  if (scl_rise) begin
                     sh_q  <= {sh_q[6:0], sda};
                     cnt_q <= cnt_q + 4'd1;
                  end else if (scl_fall && cnt_q == 4'd8) begin
                     cnt_q <= '0;
                     st_q  <= ST_IDLE;
                     unique case (kind_q)
                        RX_ADDR: if (sh_q[7:1] == {DEV_ADDR_HI, strap}) begin
                           rw_q <= sh_q[0];
                           oe_q <= 1'b1;
                           st_q <= ST_ACK;
                        end
                        RX_SUB: if (sh_q <= TOP) begin
                           ptr_q <= sh_q;
                           oe_q  <= 1'b1;
                           st_q  <= ST_ACK;
                        end
                        default: if (ptr_q <= TOP) begin
                           wr_en   <= 1'b1;
                           wr_addr <= ptr_q;
                           wr_data <= sh_q;
                           ptr_q   <= ptr_q + 8'd1;
                           oe_q    <= 1'b1;
                           st_q    <= ST_ACK;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     cnt_q <= '0;
                     if (kind_q == RX_ADDR && rw_q) begin
                        st_q  <= ST_TX;
                        sh_q  <= rd_data;
                        oe_q  <= ~rd_data[7];
                        ptr_q <= ptr_step;
                     end else begin
                        oe_q   <= 1'b0;
                        st_q   <= ST_RX;
                        kind_q <= (kind_q == RX_ADDR) ? RX_SUB : RX_DATA;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt_q == 4'd7) begin
                        oe_q  <= 1'b0;
                        cnt_q <= '0;
                        st_q  <= ST_MACK;
                     end else begin
                        cnt_q <= cnt_q + 4'd1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                        oe_q  <= ~sh_q[6];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        st_q  <= ST_TX;
                        sh_q  <= rd_data;
                        oe_q  <= ~rd_data[7];
                        ptr_q <= ptr_step;
                     end else begin
                        st_q <= ST_IDLE;
                     end
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign sda_oe  = oe_q;
   assign rd_addr = ptr_q;
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
   parameter int MAX_ADDR = 61,
   parameter int GRP_BASE = 28,
   parameter int FILT_CYC = 13
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      scl_i,
   input  logic                      sda_i,
   output logic                      sda_oe,
   input  logic                      addr_sel,
   output logic [8*(MAX_ADDR+1)-1:0] cfg_regs,
   output logic [31:0]               grp_word
);
   if (MAX_ADDR < 1 || MAX_ADDR > 254) begin : g_bad_top
      $error("MAX_ADDR must lie in 1..254");
   end
   if (GRP_BASE < 0 || GRP_BASE + 3 > MAX_ADDR) begin : g_bad_grp
      $error("group registers must lie inside the map");
   end
   if (FILT_CYC < 2) begin : g_bad_filt
      $error("FILT_CYC must be at least 2");
   end

   logic [1:0] pad_in, cond_out;
   logic       scl_c, sda_c;
   assign pad_in = {sda_i, scl_i};

   for (genvar g = 0; g < 2; g++) begin : g_line
      i2c_line_cond #(.FILT_CYC(FILT_CYC)) u_cond (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (pad_in[g]),
         .filt_en(~addr_sel),
         .line_o (cond_out[g])
      );
   end
   assign scl_c = cond_out[0];
   assign sda_c = cond_out[1];

   logic       wr_en;
   logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

   i2c_bus_fsm #(.MAX_ADDR(MAX_ADDR)) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl    (scl_c),
      .sda    (sda_c),
      .strap  (addr_sel),
      .sda_oe (sda_oe),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(rd_addr),
      .rd_data(rd_data)
   );

   i2c_reg_bank #(.MAX_ADDR(MAX_ADDR), .GRP_BASE(GRP_BASE)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .regs_flat(cfg_regs),
      .grp_word (grp_word)
   );
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk #(
   parameter int MAX_ADDR = 61,
   parameter int GRP_BASE = 28
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      scl_c,
   input logic                      sda_c,
   input logic                      sda_oe,
   input logic                      wr_en,
   input logic [7:0]                wr_addr,
   input logic [31:0]               grp_word,
   input logic [8*(MAX_ADDR+1)-1:0] cfg_regs
);
   localparam logic [7:0] GRP_LAST = 8'(GRP_BASE + 3);
   localparam logic [7:0] TOP      = 8'(MAX_ADDR);

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_c && $past(scl_c) && sda_c && !$past(sda_c)) |=> !sda_oe); // R11
   AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_c); // R11
   AST_GRP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == GRP_LAST) |=> $stable(grp_word)); // R8
   AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_addr <= TOP); // R6
   AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg_regs)); // R2
   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en); // R2
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(.MAX_ADDR(MAX_ADDR), .GRP_BASE(GRP_BASE)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_c   (scl_c),
   .sda_c   (sda_c),
   .sda_oe  (sda_oe),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .grp_word(grp_word),
   .cfg_regs(cfg_regs)
);

// File: tb/test_i2c_cfg_slave.sv
module test_i2c_cfg_slave;
   localparam int Q = 25;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic addr_sel = 1'b0;
   logic sda_oe;
   logic sda_bus;
   logic [8*62-1:0] cfg_regs;
   logic [31:0] grp_word;
   int tests = 0;
   int fails = 0;
   bit done = 0;

   always #2 clk = ~clk;
   assign sda_bus = sda_m & ~sda_oe;

   i2c_cfg_slave i_i2c_cfg_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe(sda_oe), .addr_sel(addr_sel), .cfg_regs(cfg_regs), .grp_word(grp_word)
   );

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] rv(input int a);
      return 8'(a) ^ 8'hA5;
   endfunction

   function automatic logic [7:0] regp(input int a);
      return cfg_regs[8*a +: 8];
   endfunction

   task automatic bstart();
      sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
   endtask
   task automatic bstop();
      sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q);
   endtask
   task automatic wbit(input logic b, input bit gl);
      sda_m = b; wq(Q);
      if (gl) begin scl_m = 1; wq(5); scl_m = 0; wq(5); end
      scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
   endtask
   task automatic rbit(output logic b);
      sda_m = 1; wq(Q); scl_m = 1; wq(Q); b = sda_bus; wq(Q); scl_m = 0; wq(Q);
   endtask
   task automatic wbyte(input logic [7:0] d, input bit gl, output bit ack);
      logic b;
      for (int i = 7; i >= 0; i--) wbit(d[i], gl);
      rbit(b);
      ack = !b;
   endtask
   task automatic rbyte(output logic [7:0] d, input bit mack);
      logic b;
      for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
      wbit(!mack, 0);
   endtask

   task automatic reg_write1(input string req, input logic [7:0] dev, input logic [7:0] sub,
                             input logic [7:0] d);
      bit a;
      bstart();
      wbyte(dev, 0, a); check({req, " dev ack"}, a, 1);
      wbyte(sub, 0, a); check({req, " sub ack"}, a, 1);
      wbyte(d, 0, a);   check({req, " data ack"}, a, 1);
      bstop();
   endtask

   task automatic reg_read1(input logic [7:0] sub, output logic [7:0] d);
      bit a;
      bstart();
      wbyte(8'hD4, 0, a); wbyte(sub, 0, a);
      bstart();
      wbyte(8'hD5, 0, a);
      rbyte(d, 0);
      bstop();
   endtask

   // R4 R11 reset state
   task automatic t_reset();
      logic [7:0] d;
      check("R4 reg0 port", regp(0), 8'hA5);
      check("R4 reg3D port", regp(61), 8'h98);
      check("R4 grp_word", grp_word, 32'hBABBB8B9);
      check("R11 oe idle", sda_oe, 0);
      reg_read1(8'h00, d);
      check("R4 R3 bus read reg0", d, 8'hA5);
   endtask

   // R2 R3 burst write then burst read
   task automatic t_burst();
      bit a;
      logic [7:0] d;
      bstart();
      wbyte(8'hD4, 0, a); check("R2 addr ack", a, 1);
      wbyte(8'h05, 0, a); check("R2 sub ack", a, 1);
      wbyte(8'h11, 0, a); check("R2 d0 ack", a, 1);
      wbyte(8'h22, 0, a); check("R2 d1 ack", a, 1);
      wbyte(8'h33, 0, a); check("R2 d2 ack", a, 1);
      bstop();
      check("R2 reg5", regp(5), 8'h11);
      check("R2 reg6", regp(6), 8'h22);
      check("R2 reg7", regp(7), 8'h33);
      check("R2 reg8 untouched", regp(8), rv(8));
      bstart();
      wbyte(8'hD4, 0, a); wbyte(8'h05, 0, a);
      bstart();
      wbyte(8'hD5, 0, a); check("R3 read addr ack", a, 1);
      rbyte(d, 1); check("R3 rd0", d, 8'h11);
      rbyte(d, 1); check("R3 rd1", d, 8'h22);
      rbyte(d, 0); check("R3 rd2", d, 8'h33);
      bstop();
   endtask

   // R1 wrong address ignored
   task automatic t_addr_low();
      bit a;
      bstart();
      wbyte(8'hD6, 0, a); check("R1 foreign addr nack", a, 0);
      wbyte(8'h09, 0, a); check("R1 no sub ack", a, 0);
      wbyte(8'h77, 0, a); check("R1 no data ack", a, 0);
      bstop();
      check("R1 reg9 unchanged", regp(9), rv(9));
   endtask

   // R5 invalid subaddress
   task automatic t_bad_sub();
      bit a;
      bstart();
      wbyte(8'hD4, 0, a);
      wbyte(8'h3E, 0, a); check("R5 sub 3E nack", a, 0);
      wbyte(8'h12, 0, a); check("R5 idle after nack", a, 0);
      bstop();
      check("R5 reg3D unchanged", regp(61), 8'h98);
      bstart();
      wbyte(8'hD4, 0, a);
      wbyte(8'h3D, 0, a); check("R5 sub 3D ack", a, 1);
      bstop();
   endtask

   // R6 write overrun, R7 read overrun
   task automatic t_overrun();
      bit a;
      logic [7:0] d;
      bstart();
      wbyte(8'hD4, 0, a); wbyte(8'h3C, 0, a);
      wbyte(8'h5A, 0, a); check("R6 3C ack", a, 1);
      wbyte(8'h6B, 0, a); check("R6 3D ack", a, 1);
      wbyte(8'h7C, 0, a); check("R6 past top nack", a, 0);
      wbyte(8'h7D, 0, a); check("R6 idle after nack", a, 0);
      bstop();
      check("R6 reg3C", regp(60), 8'h5A);
      check("R6 reg3D", regp(61), 8'h6B);
      bstart();
      wbyte(8'hD4, 0, a); wbyte(8'h3C, 0, a);
      bstart();
      wbyte(8'hD5, 0, a);
      rbyte(d, 1); check("R7 rd 3C", d, 8'h5A);
      rbyte(d, 1); check("R7 rd 3D", d, 8'h6B);
      rbyte(d, 1); check("R7 past top 1", d, 8'h6B);
      rbyte(d, 0); check("R7 past top 2", d, 8'h6B);
      bstop();
      check("R11 released after read", sda_oe, 0);
   endtask

   // R8 grouped word commit
   task automatic t_group();
      bit a;
      bstart();
      wbyte(8'hD4, 0, a); wbyte(8'h1C, 0, a);
      wbyte(8'h01, 0, a); wbyte(8'h02, 0, a); wbyte(8'h03, 0, a);
      bstop();
      check("R8 partial no commit", grp_word, 32'hBABBB8B9);
      check("R8 shadow byte 1E", regp(30), 8'h03);
      reg_write1("R8", 8'hD4, 8'h1F, 8'h44);
      check("R8 commit on last", grp_word, 32'h44030201);
   endtask

   // R9 out-of-sequence stop and start
   task automatic t_oos();
      bit a;
      bstart();
      wbyte(8'hD4, 0, a); wbyte(8'h10, 0, a);
      for (int i = 0; i < 4; i++) wbit(1'b0, 0);
      bstop();
      check("R9 stop mid byte no store", regp(16), rv(16));
      check("R11 oe clear after stop", sda_oe, 0);
      bstart();
      wbyte(8'hD4, 0, a); wbyte(8'h11, 0, a);
      for (int i = 0; i < 3; i++) wbit(1'b0, 0);
      bstart();
      wbyte(8'hD4, 0, a); check("R9 restart addr ack", a, 1);
      wbyte(8'h12, 0, a); check("R9 restart sub ack", a, 1);
      wbyte(8'h99, 0, a); check("R9 restart data ack", a, 1);
      bstop();
      check("R9 reg12 written", regp(18), 8'h99);
      check("R9 reg11 untouched", regp(17), rv(17));
   endtask

   // R10 short SCL glitches rejected with strap low
   task automatic t_glitch();
      bit a;
      bstart();
      wbyte(8'hD4, 1, a); check("R10 addr ack with glitches", a, 1);
      wbyte(8'h20, 1, a); check("R10 sub ack with glitches", a, 1);
      wbyte(8'hC3, 1, a); check("R10 data ack with glitches", a, 1);
      bstop();
      check("R10 reg20", regp(32), 8'hC3);
   endtask

   // R1 strap high selects the other address
   task automatic t_strap_high();
      bit a;
      addr_sel = 1'b1;
      wq(10);
      bstart();
      wbyte(8'hD4, 0, a); check("R1 D4 nack when strap high", a, 0);
      bstop();
      reg_write1("R1 strap high", 8'hD6, 8'h21, 8'h5E);
      check("R1 reg21", regp(33), 8'h5E);
      addr_sel = 1'b0;
      wq(10);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      wq(10);
      rst_n = 1'b1;
      wq(5);
      t_reset();
      t_burst();
      t_addr_low();
      t_bad_sub();
      t_overrun();
      t_group();
      t_oos();
      t_glitch();
      t_strap_high();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule